// File: doc/BRIEF.md
# Direct-Drive LCD Segment Driver with Toggling Backplane

This block turns a latched three-and-a-half digit reading into the drive waveforms for a static (one common plane) liquid crystal display. The reading is three BCD digits (units, tens, hundreds), a single bit for the leading "1", a sign flag and an overrange flag. Each BCD digit is decoded to seven segment lines. The leading "1" uses one line that lights both of its segments. A separate line drives the minus sign.

The block divides its oscillator clock to make a backplane square wave. Every segment line is a copy of the backplane. An unlit segment copies it in phase. A lit segment copies it inverted. The panel therefore sees no net DC in normal use. The inputs are sampled only at backplane transitions, so no segment changes in the middle of a phase.

A lamp-test input lights every segment, so the panel reads -1888. In this mode the segment lines are held at a static high level. The backplane keeps running.

Top module: `lcd_segment_driver`

## Requirements
- R1: After reset the backplane starts low and toggles every DIV/2 clock cycles, giving a square wave with a period of DIV clock cycles. DIV is even, and its default is 800.
- R2: In normal mode each segment line and the sign line equals the backplane when its segment is unlit, and the inverse of the backplane when it is lit.
- R3: Each of the three low digits is decoded with bit 0 = a, bit 1 = b, and so on up to bit 6 = g. The lit sets are: 0→abcdef, 1→bc, 2→abdeg, 3→abcdg, 4→bcfg, 5→acdfg, 6→acdefg, 7→abc, 8→abcdefg, 9→abcdfg.
- R4: BCD codes 10 to 15 on any low digit light no segment of that digit.
- R5: The thousands line is lit when the thousands input is 1 and unlit when it is 0.
- R6: The sign line is lit when the negative input is 1.
- R7: When overrange is 1, all 21 segments of the three low digits are unlit. The thousands and sign lines still follow their inputs.
- R8: While lamp test is active, all 23 segment and sign lines are held constantly high and the backplane keeps toggling. Lamp test takes precedence over the digits and over overrange.
- R9: Inputs are captured only on the clock edge where the backplane toggles. The segment and sign lines change only in cycles where the backplane changes.
- R10: During and right after reset the backplane and all segment and sign lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous reset, active low |
| onesBcd | input | 4 | Units digit, BCD |
| tensBcd | input | 4 | Tens digit, BCD |
| hundredsBcd | input | 4 | Hundreds digit, BCD |
| thousandBit | input | 1 | Leading "1" is shown |
| negative | input | 1 | Reading is negative |
| overrange | input | 1 | Blank the three low digits |
| lampTest | input | 1 | Light every segment as static high |
| onesSeg | output | 7 | Units segment lines, bit 0 = a … bit 6 = g |
| tensSeg | output | 7 | Tens segment lines |
| hundredsSeg | output | 7 | Hundreds segment lines |
| thousandSeg | output | 1 | Combined line for both segments of the "1" |
| signSeg | output | 1 | Minus sign line |
| backplane | output | 1 | Common plane square wave |

## Verification
The units digit is swept through all sixteen codes. The tens and hundreds digits are offset from it, so each digit sees every code. The thousands and sign bits are derived from the sweep value. Each reading is checked in both backplane phases. This separates a wrong decode from a wrong phase relation, and separates the blanking of codes 10 to 15 from a missing segment. Overrange with a digit of 8 and lamp test combined with overrange show that blanking and forcing follow the stated precedence. Lamp test is held across several phases to confirm the static level. Inputs changed in the middle of a phase confirm that the old reading stays on the lines until the next backplane edge. Counting the clocks between edges confirms the divide ratio.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int LowDigits = 3;
  localparam int SegPerDigit = 7;
  localparam int LowSegs = LowDigits * SegPerDigit;
  localparam int TotalLines = LowSegs + 2;

  typedef struct packed {
    logic capture;  // backplane is about to toggle: take new reading
    logic phase;    // present backplane level
  } lcdStrobe_t;
endpackage

// File: rtl/lcd_drv_digit.sv
module lcd_drv_digit (
  input  logic [3:0] code,
  input  logic       blank,
  output logic [6:0] seg
);
  always_comb begin
    unique case (code)
      4'd0: seg = 7'h3F;
      4'd1: seg = 7'h06;
      4'd2: seg = 7'h5B;
      4'd3: seg = 7'h4F;
      4'd4: seg = 7'h66;
      4'd5: seg = 7'h6D;
      4'd6: seg = 7'h7D;
      4'd7: seg = 7'h07;
      4'd8: seg = 7'h7F;
      4'd9: seg = 7'h6F;
      default: seg = 7'h00;  // codes 10..15 show nothing
    endcase
    if (blank) seg = 7'h00;
  end
endmodule

// File: rtl/lcd_drv_ctrl.sv
module lcd_drv_ctrl
  import lcd_drv_pkg::*;
#(
  parameter int DIV = 800
) (
  input  logic       clk,
  input  logic       rstN,
  output lcdStrobe_t strb
);
  localparam int Half = DIV / 2;
  localparam int CntW = (Half > 1) ? $clog2(Half) : 1;
  localparam logic [CntW-1:0] LastCnt = CntW'(Half - 1);

  logic [CntW-1:0] cnt;
  logic            bpQ;
  logic            wrap;

  assign wrap = (cnt == LastCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      bpQ <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      bpQ <= ~bpQ;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign strb.capture = wrap;
  assign strb.phase   = bpQ;

  always_comb begin
    if (rstN) assert_count_range_R1: assert (cnt <= LastCnt);
  end

  assert_toggle_on_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bpQ) |-> ($past(cnt) == LastCnt));
endmodule

// File: rtl/lcd_drv_data.sv
module lcd_drv_data
  import lcd_drv_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  lcdStrobe_t              strb,
  input  logic [LowDigits*4-1:0]  lowBcd,
  input  logic                    thousandBit,
  input  logic                    negative,
  input  logic                    overrange,
  input  logic                    lampTest,
  output logic [TotalLines-1:0]   lines
);
  logic [LowDigits-1:0][SegPerDigit-1:0] lowSeg;
  logic [TotalLines-1:0] litNext;
  logic [TotalLines-1:0] litQ;
  logic                  testQ;

  for (genvar d = 0; d < LowDigits; d++) begin : g_digit
    lcd_drv_digit u_digit (
      .code  (lowBcd[d*4 +: 4]),
      .blank (overrange),
      .seg   (lowSeg[d])
    );
  end

  assign litNext = {negative, thousandBit, lowSeg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      litQ  <= '0;
      testQ <= 1'b0;
    end else if (strb.capture) begin
      litQ  <= litNext;
      testQ <= lampTest;
    end
  end

  always_comb begin
    if (testQ) lines = '1;
    else       lines = litQ ^ {TotalLines{strb.phase}};
  end

  assert_no_midphase_change_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lines) |-> !$stable(strb.phase));

  assert_overrange_blank_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && overrange && !lampTest) |=>
      (lines[LowSegs-1:0] == {LowSegs{strb.phase}}));

  assert_lamp_all_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && lampTest) |=> (&lines));

  assert_lamp_static_R8: assert property (@(posedge clk) disable iff (!rstN)
    (testQ && $past(testQ)) |-> $stable(lines));
endmodule

// File: rtl/lcd_segment_driver.sv
module lcd_segment_driver
  import lcd_drv_pkg::*;
#(
  parameter int DIV = 800
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] onesBcd,
  input  logic [3:0] tensBcd,
  input  logic [3:0] hundredsBcd,
  input  logic       thousandBit,
  input  logic       negative,
  input  logic       overrange,
  input  logic       lampTest,
  output logic [6:0] onesSeg,
  output logic [6:0] tensSeg,
  output logic [6:0] hundredsSeg,
  output logic       thousandSeg,
  output logic       signSeg,
  output logic       backplane
);
  lcdStrobe_t            strb;
  logic [TotalLines-1:0] lines;

  lcd_drv_ctrl #(.DIV(DIV)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb)
  );

  lcd_drv_data u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .lowBcd      ({hundredsBcd, tensBcd, onesBcd}),
    .thousandBit (thousandBit),
    .negative    (negative),
    .overrange   (overrange),
    .lampTest    (lampTest),
    .lines       (lines)
  );

  assign onesSeg     = lines[6:0];
  assign tensSeg     = lines[13:7];
  assign hundredsSeg = lines[20:14];
  assign thousandSeg = lines[21];
  assign signSeg     = lines[22];
  assign backplane   = strb.phase;
endmodule

// File: tb/lcd_segment_driver_tb.sv
module lcd_segment_driver_tb;
  localparam int DIV  = 8;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN;
  logic [3:0] onesBcd, tensBcd, hundredsBcd;
  logic       thousandBit, negative, overrange, lampTest;
  logic [6:0] onesSeg, tensSeg, hundredsSeg;
  logic       thousandSeg, signSeg, backplane;

  int checks = 0;
  int fails  = 0;

  lcd_segment_driver #(.DIV(DIV)) u_dut (
    .clk(clk), .rstN(rstN), .onesBcd(onesBcd), .tensBcd(tensBcd),
    .hundredsBcd(hundredsBcd), .thousandBit(thousandBit), .negative(negative),
    .overrange(overrange), .lampTest(lampTest), .onesSeg(onesSeg),
    .tensSeg(tensSeg), .hundredsSeg(hundredsSeg), .thousandSeg(thousandSeg),
    .signSeg(signSeg), .backplane(backplane)
  );

  function automatic logic [22:0] allLines();
    return {signSeg, thousandSeg, hundredsSeg, tensSeg, onesSeg};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Lit set per segment, stated as the digits that light it
  function automatic logic [6:0] litOf(input int d);
    logic [6:0] s;
    if (d > 9) return 7'd0;
    s[0] = !(d inside {1, 4});
    s[1] = !(d inside {5, 6});
    s[2] = (d != 2);
    s[3] = !(d inside {1, 4, 7});
    s[4] = (d inside {0, 2, 6, 8});
    s[5] = !(d inside {1, 2, 3, 7});
    s[6] = !(d inside {0, 1, 7});
    return s;
  endfunction

  task automatic waitToggle();
    logic prev;
    prev = backplane;
    do @(negedge clk); while (backplane == prev);
  endtask

  // Compare the lines against a lit pattern in the present phase
  task automatic checkPhase(input string lowReq, input logic [22:0] lit);
    logic [22:0] exp;
    exp = backplane ? ~lit : lit;
    check(lowReq, {11'd0, allLines() & 23'h1FFFFF}, {11'd0, exp & 23'h1FFFFF});
    check("R5", {31'd0, thousandSeg}, {31'd0, exp[21]});
    check("R6", {31'd0, signSeg}, {31'd0, exp[22]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [22:0] lit, oldLit;
    int n;
    rstN = 1'b0; onesBcd = 0; tensBcd = 0; hundredsBcd = 0;
    thousandBit = 0; negative = 0; overrange = 0; lampTest = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {8'd0, backplane, allLines()}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", {8'd0, backplane, allLines()}, 32'd0);

    // R1: divide ratio, both levels
    waitToggle();
    for (int k = 0; k < 2; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (backplane == ((k == 0) ? 1'b1 : 1'b0));
      check("R1", n, HALF);
    end

    // R3/R4/R5/R6/R2: sweep of all codes
    for (int v = 0; v < 16; v++) begin
      onesBcd = 4'(v); tensBcd = 4'((v + 3) % 16); hundredsBcd = 4'((v + 7) % 16);
      thousandBit = v[0]; negative = v[1];
      lit = {v[1], v[0], litOf((v + 7) % 16), litOf((v + 3) % 16), litOf(v)};
      waitToggle();
      checkPhase((v > 9) ? "R4" : "R3", lit);
      waitToggle();
      checkPhase("R2", lit);
    end

    // R9: change mid-phase, old reading remains until next edge
    onesBcd = 4'd2; tensBcd = 4'd5; hundredsBcd = 4'd9; thousandBit = 1; negative = 0;
    waitToggle();
    oldLit = {1'b0, 1'b1, litOf(9), litOf(5), litOf(2)};
    onesBcd = 4'd6; tensBcd = 4'd1; hundredsBcd = 4'd4; thousandBit = 0; negative = 1;
    for (int k = 0; k < HALF - 1; k++) begin
      @(negedge clk);
      check("R9", {9'd0, allLines()}, {9'd0, backplane ? ~oldLit : oldLit});
    end
    waitToggle();
    checkPhase("R9", {1'b1, 1'b0, litOf(4), litOf(1), litOf(6)});

    // R7: overrange blanks low digits only
    onesBcd = 4'd8; tensBcd = 4'd8; hundredsBcd = 4'd8; thousandBit = 1; negative = 1;
    overrange = 1;
    waitToggle();
    checkPhase("R7", {1'b1, 1'b1, 21'd0});
    waitToggle();
    checkPhase("R7", {1'b1, 1'b1, 21'd0});

    // R8: lamp test wins over overrange and digits, static high
    onesBcd = 0; tensBcd = 0; hundredsBcd = 0; thousandBit = 0; negative = 0;
    lampTest = 1;
    waitToggle();
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < HALF; j++) begin
        check("R8", {9'd0, allLines()}, {9'd0, 23'h7FFFFF});
        @(negedge clk);
      end
    end
    n = 0;
    begin
      logic prev;
      prev = backplane;
      for (int j = 0; j < DIV; j++) begin
        @(negedge clk);
        if (backplane != prev) n++;
        prev = backplane;
      end
    end
    check("R8", n, 2);

    // Leave test: normal drive returns
    lampTest = 0; overrange = 0; onesBcd = 4'd7; tensBcd = 4'd0; hundredsBcd = 4'd3;
    waitToggle();
    checkPhase("R2", {1'b0, 1'b0, litOf(3), litOf(0), litOf(7)});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule